// File: doc/BRIEF.md
# SPI Master with Selectable Clock Modes

This block drives one serial peripheral as the clock-owning side of a full-duplex byte exchange. A host places a byte on `tx_data`, chooses the clock idle level (`cpol`) and the sampling phase (`cpha`), sets a divider value, and pulses `start`. The block then pulls `ss_n` low, produces sixteen clock edges on `sck`, shifts the byte out on `mosi` and assembles the byte arriving on `miso`. When the exchange ends, the received byte appears on `rx_data` and `done` pulses for one cycle.

The two mode inputs are latched when an exchange begins and compared with the live inputs on every cycle. If either one moves while the block is busy, the exchange is dropped at once: select is released, `sck` goes to the idle level of the new polarity, no completion is signalled and the previously received byte is kept. The divider sets how many system clocks each half of the serial clock lasts, so the serial rate can match a slow peripheral.

Top module: `spi_mode_master`

## Requirements
- R1: Each exchange moves one byte in each direction at the same time, most significant bit first: the peripheral captures `tx_data` bit 7 first, and the first `miso` bit captured lands in `rx_data` bit 7.
- R2: `ss_n` goes low only in the cycle after an accepted `start`, before the first `sck` edge, stays low through all sixteen edges, and is high whenever `busy` is low.
- R3: While idle, `sck` sits at the level of `cpol` (low for 0, high for 1), following a change of `cpol` one cycle later.
- R4: With `cpha` = 0 the master samples `miso` on edges 1, 3, 5, ... and changes `mosi` on even edges; with `cpha` = 1 it changes `mosi` on odd edges and samples on edges 2, 4, 6, .... Hence modes 0 and 3 capture on the rising edge, modes 1 and 2 on the falling edge.
- R5: With `cpha` = 0, `mosi` already carries `tx_data` bit 7 in the first cycle that `ss_n` is low.
- R6: Every half period of `sck` lasts `clk_div` + 1 system clocks, and each exchange has exactly 16 `sck` edges, ending at the idle level.
- R7: One half period after the 16th edge, `ss_n` rises, `rx_data` takes the received byte and `done` is high for exactly one cycle in that same cycle.
- R8: `busy` is high from the cycle after an accepted `start` until the cycle in which `done` pulses or an abort takes effect.
- R9: A `start` pulse while `busy` is high is ignored: the running exchange keeps its byte and its 16-edge length.
- R10: A change of `cpol` or `cpha` while `busy` is high ends the exchange on the next clock: `busy` low, `ss_n` high, `sck` at the new `cpol` level, no `done` pulse, and `rx_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an exchange |
| tx_data | input | BYTE_W | Byte to send |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on odd edges, 1: sample on even edges |
| clk_div | input | DIV_W | Half period of `sck` minus one, in system clocks |
| rx_data | output | BYTE_W | Last completely received byte |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Exchange in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| ss_n | output | 1 | Active-low peripheral select |

## Verification
The bench builds the block with its default 8-bit byte and 8-bit divider and plays the peripheral itself, choosing `clk_div` from 0 to 4 so that both the fastest case (a serial edge every system clock, where the first edge directly follows select) and multi-cycle half periods are timed edge by edge. All four modes are covered with random and extreme bytes, and aborts are forced through both `cpol` and `cpha` at early and late edges, including after the last edge, together with a start pulse injected mid-exchange.

// File: rtl/spi_m_pkg.sv
package spi_m_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TAIL = 2'd2
    } xfer_state_t;

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R6: with a divider above zero, two ticks never come back to back
    p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && $past(tick) && (div != '0) && $stable(div) |-> !tick);

endmodule

// File: rtl/spi_edge_decode.sv
module spi_edge_decode #(
    parameter int BYTE_W = 8,
    localparam int EDGES  = 2 * BYTE_W,
    localparam int EDGE_W = $clog2(EDGES) + 1
) (
    input  logic [EDGE_W-1:0] edge_idx,
    input  logic              cpha,
    output logic              sample_en,
    output logic              shift_en,
    output logic              last_edge
);

    localparam logic [EDGE_W-1:0] LAST_IDX = EDGE_W'(EDGES - 1);

    logic odd_edge;

    always_comb begin
        // edge_idx counts edges already made; index 0 is the first (odd) edge
        odd_edge  = ~edge_idx[0];
        last_edge = (edge_idx == LAST_IDX);
        if (cpha) begin
            sample_en = ~odd_edge;
            shift_en  = odd_edge && (edge_idx != '0);
        end else begin
            sample_en = odd_edge;
            shift_en  = ~odd_edge && !last_edge;
        end
    end

endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
    import spi_m_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  clk_div,
    output logic [BYTE_W-1:0] rx_data,
    output logic              done,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);

    localparam int EDGES  = 2 * BYTE_W;
    localparam int EDGE_W = $clog2(EDGES) + 1;

    typedef struct packed {
        xfer_state_t       st;
        logic              sck;
        logic              ss_n;
        logic [BYTE_W-1:0] tx_sh;
        logic [BYTE_W-1:0] rx_sh;
        logic [BYTE_W-1:0] rx_buf;
        logic              done;
        logic              cpol;
        logic              cpha;
        logic [EDGE_W-1:0] edge_cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic tick;
    logic run;
    logic sample_en, shift_en, last_edge;
    logic mode_moved;

    assign run = (r_q.st != ST_IDLE);

    spi_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (clk_div),
        .tick  (tick)
    );

    spi_edge_decode #(.BYTE_W(BYTE_W)) u_edge (
        .edge_idx  (r_q.edge_cnt),
        .cpha      (r_q.cpha),
        .sample_en (sample_en),
        .shift_en  (shift_en),
        .last_edge (last_edge)
    );

    always_comb begin
        mode_moved = run && ((cpol != r_q.cpol) || (cpha != r_q.cpha));
        r_d        = r_q;
        r_d.done   = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                r_d.sck  = cpol;
                r_d.ss_n = 1'b1;
                if (start) begin
                    r_d.st       = ST_XFER;
                    r_d.ss_n     = 1'b0;
                    r_d.tx_sh    = tx_data;
                    r_d.cpol     = cpol;
                    r_d.cpha     = cpha;
                    r_d.edge_cnt = '0;
                end
            end
            ST_XFER: begin
                if (tick) begin
                    r_d.sck      = ~r_q.sck;
                    r_d.edge_cnt = r_q.edge_cnt + 1'b1;
                    if (sample_en) begin
                        r_d.rx_sh = {r_q.rx_sh[BYTE_W-2:0], miso};
                    end
                    if (shift_en) begin
                        r_d.tx_sh = {r_q.tx_sh[BYTE_W-2:0], 1'b0};
                    end
                    if (last_edge) begin
                        r_d.st = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    r_d.st     = ST_IDLE;
                    r_d.ss_n   = 1'b1;
                    r_d.rx_buf = r_q.rx_sh;
                    r_d.done   = 1'b1;
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.ss_n = 1'b1;
            end
        endcase

        if (mode_moved) begin
            r_d.st     = ST_IDLE;
            r_d.ss_n   = 1'b1;
            r_d.sck    = cpol;
            r_d.done   = 1'b0;
            r_d.rx_buf = r_q.rx_buf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.ss_n     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_data = r_q.rx_buf;
    assign done    = r_q.done;
    assign busy    = run;
    assign sck     = r_q.sck;
    assign ss_n    = r_q.ss_n;
    assign mosi    = run ? r_q.tx_sh[BYTE_W-1] : 1'b0;

    // R2: select falls only after an accepted start
    p_sel_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n) |-> $past(start) && !$past(busy));

    // R2: select rises only when the block has left its busy state
    p_sel_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |-> !busy);

    // R3: idle clock follows the polarity input
    p_idle_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !busy && !$past(busy) && $stable(cpol) |-> sck == cpol);

    // R5: first data bit present when select asserts in phase 0
    p_first_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n) && !$past(cpha) |-> mosi == $past(tx_data[BYTE_W-1]));

    // R6: never more edges than one byte needs
    p_edge_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.edge_cnt <= EDGE_W'(EDGES));

    // R7: done lasts one cycle and coincides with a released select
    p_done_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ss_n && !busy);

    // R8: an accepted start makes the block busy on the next cycle
    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy);

    // R10: a mode change mid-exchange drops it without completion
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ((cpol != r_q.cpol) || (cpha != r_q.cpha))
        |=> !busy && !done && ss_n && (sck == $past(cpol)) && $stable(rx_data));

endmodule

// File: tb/spi_mode_master_test.sv
module spi_mode_master_test;

    localparam int BW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [BW-1:0] tx_data = '0;
    logic          cpol = 1'b0;
    logic          cpha = 1'b0;
    logic [DW-1:0] clk_div = '0;
    logic [BW-1:0] rx_data;
    logic          done;
    logic          busy;
    logic          sck;
    logic          mosi;
    logic          miso = 1'b0;
    logic          ss_n;

    int n_chk = 0;
    int n_bad = 0;
    bit summary_out = 0;

    always #10 clk = ~clk;

    spi_mode_master #(.BYTE_W(BW), .DIV_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
        .cpol(cpol), .cpha(cpha), .clk_div(clk_div), .rx_data(rx_data),
        .done(done), .busy(busy), .sck(sck), .mosi(mosi), .miso(miso),
        .ss_n(ss_n)
    );

    function automatic int half_period(input logic [DW-1:0] dv);
        return int'(dv) + 1;
    endfunction

    function automatic bit samples_here(input logic ph, input int edge_no);
        return ph ? (edge_no % 2 == 0) : (edge_no % 2 == 1);
    endfunction

    function automatic int next_miso_bit(input logic ph, input int edge_no);
        // index of the peripheral bit to present after a drive edge
        return ph ? (BW - 1 - (edge_no - 1) / 2) : (BW - 1 - edge_no / 2);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // abort_at: edge after which a mode input flips (-1: none); flip_pol selects which
    // restart_at: edge after which a stray start is pulsed (-1: none)
    task automatic xfer(input logic [BW-1:0] mtx, input logic [BW-1:0] stx,
                        input logic pol, input logic ph, input logic [DW-1:0] dv,
                        input int abort_at, input bit flip_pol, input int restart_at);
        logic [BW-1:0] cap = '0;
        logic [BW-1:0] old_rx;
        logic          prev_sck;
        int            edges = 0;
        int            cyc = 0;
        int            bad_gap = 0;
        bit            got_done = 0;
        bit            aborted = 0;
        bit            sel_bad = 0;
        old_rx = rx_data;
        @(negedge clk);
        cpol = pol; cpha = ph; clk_div = dv; tx_data = mtx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tx_data = ~mtx;
        check(busy == 1'b1, "R8 busy after start", busy, 1);
        check(ss_n == 1'b0 && sck == pol, "R2 select before first edge", {ss_n, sck}, {1'b0, pol});
        if (!ph) check(mosi == mtx[BW-1], "R5 first bit at select", mosi, mtx[BW-1]);
        if (!ph) miso = stx[BW-1];
        prev_sck = sck;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (done) begin
                got_done = 1;
                break;
            end
            if (sck != prev_sck) begin
                edges++;
                if (edges > 1 && cyc != half_period(dv)) bad_gap++;
                cyc = 0;
                if (ss_n) sel_bad = 1;
                if (samples_here(ph, edges)) begin
                    cap = {cap[BW-2:0], mosi};
                end else if (edges < 2 * BW) begin
                    miso = stx[next_miso_bit(ph, edges)];
                end
                if (edges == abort_at) begin
                    if (flip_pol) cpol = ~pol; else cpha = ~ph;
                    @(negedge clk);
                    aborted = 1;
                    break;
                end
                if (edges == restart_at) start = 1'b1;
            end
            prev_sck = sck;
        end
        if (aborted) begin
            check(busy == 1'b0 && ss_n == 1'b1, "R10 abort releases", {busy, ss_n}, 2'b01);
            check(sck == cpol, "R10 sck at new idle level", sck, cpol);
            for (int k = 0; k < 3 * half_period(dv) + 4; k++) begin
                @(negedge clk);
                if (done) got_done = 1;
            end
            check(!got_done, "R10 no done on abort", got_done, 0);
            check(rx_data == old_rx, "R10 rx_data kept", rx_data, old_rx);
            check(sck == cpol && ss_n, "R3 idle after abort", {sck, ss_n}, {cpol, 1'b1});
        end else begin
            check(got_done, "R7 done seen", got_done, 1);
            check(ss_n == 1'b1 && busy == 1'b0, "R7 select released with done", {ss_n, busy}, 2'b10);
            check(rx_data == stx, "R1 received byte", rx_data, stx);
            check(cap == mtx, "R1/R4 peripheral captured byte", cap, mtx);
            check(edges == 2 * BW, "R6 edge count", edges, 2 * BW);
            check(bad_gap == 0, "R6 half period", bad_gap, 0);
            check(!sel_bad, "R2 select held low", sel_bad, 0);
            check(sck == pol, "R3 sck idle at end", sck, pol);
            @(negedge clk);
            check(done == 1'b0, "R7 done single cycle", done, 0);
            if (restart_at >= 0) check(busy == 1'b0, "R9 stray start ignored", busy, 0);
        end
        cpol = pol; cpha = ph;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ss_n == 1'b1 && busy == 1'b0 && done == 1'b0, "R2 reset state",
              {ss_n, busy, done}, 3'b100);
        check(sck == 1'b0 && mosi == 1'b0, "R3 reset idle clock", {sck, mosi}, 2'b00);
        cpol = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(sck == 1'b1, "R3 idle follows cpol", sck, 1);
        cpol = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(sck == 1'b0, "R3 idle follows cpol low", sck, 0);

        // directed: every mode at the fastest divider and extreme bytes
        for (int m = 0; m < 4; m++) begin
            xfer(8'hA5, 8'h3C, m[1], m[0], 8'd0, -1, 0, -1);
            xfer(8'hFF, 8'h00, m[1], m[0], 8'd2, -1, 0, -1);
            xfer(8'h00, 8'hFF, m[1], m[0], 8'd1, -1, 0, -1);
        end
        // R9: stray start mid-exchange
        xfer(8'h96, 8'h69, 1'b0, 1'b1, 8'd1, -1, 0, 5);
        xfer(8'h1E, 8'hE1, 1'b1, 1'b0, 8'd0, -1, 0, 9);
        // R10: aborts by each mode input, early and at the last edge
        xfer(8'h5A, 8'hC3, 1'b0, 1'b0, 8'd1, 3, 0, -1);
        xfer(8'h5A, 8'hC3, 1'b1, 1'b1, 8'd2, 7, 1, -1);
        xfer(8'h81, 8'h7E, 1'b0, 1'b1, 8'd0, 16, 1, -1);
        xfer(8'h81, 8'h7E, 1'b1, 1'b0, 8'd3, 1, 0, -1);

        // random exchanges
        for (int t = 0; t < 40; t++) begin
            logic [BW-1:0] a = BW'($urandom);
            logic [BW-1:0] b = BW'($urandom);
            logic [1:0]    md = 2'($urandom);
            logic [DW-1:0] dv = DW'($urandom_range(0, 4));
            xfer(a, b, md[1], md[0], dv, -1, 0, -1);
        end

        if (!summary_out) begin
            summary_out = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!summary_out) begin
            summary_out = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule